// File: doc/BRIEF.md
# Variable-Window Register Stack Cache

The block keeps the most recent part of a procedure register stack in a 128-word circular register file. The rest of the stack lives in word-addressed backing memory. A call or an interrupt entry asks for a window of any size from 0 to 128 words. A return gives a number of words back and states how many words under the new top must be resident.

When a new window does not fit, the block writes exactly the missing number of words to memory, oldest resident word first. When a return leaves fewer resident words than the caller asked for, the block reads back exactly the shortfall, newest word first. Spills and fills are decoupled: after a spill, later returns cause no traffic as long as enough words stay resident. Call depth can therefore move across the whole file without any memory access.

Register reads and writes use an offset counted down from the stack top. Offset 0 is the most recently allocated word. The physical slot is taken modulo 128.

Top module: `regstack_cache`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `err` and `mem_req` are 0, `resident` is 0 and `mem_addr` (the memory stack pointer) is 0.
- R2: An allocation of n words with resident+n ≤ 128 causes no memory request, keeps `busy` low, and raises `resident` by n on the next cycle.
- R3: An allocation of n words with resident+n > 128 issues exactly resident+n−128 memory writes (`mem_we`=1). The writes go oldest resident word first, at ascending addresses starting at the memory stack pointer, which advances by one per acknowledge. Afterwards `resident` is 128.
- R4: An allocation with a size above 128 pulses `err` for one cycle, one cycle after the request, and leaves `resident`, `mem_addr` and the register contents unchanged.
- R5: A release of n words with keep k gives resident' = max(resident−n, 0), or resident' = 0 and memory pointer = new depth when n ≥ resident. If k ≤ resident', no memory request follows, even after earlier spills.
- R6: If k > resident' after a release, the block issues exactly k−resident' memory reads (`mem_we`=0) at descending addresses starting at pointer−1. It places each word back in its original register, and `resident` ends at k.
- R7: An interrupt entry that allocates m words, followed by a release of m words with keep equal to the residency before entry, restores the prior `resident`, `mem_addr` and register values.
- R8: A release whose size exceeds the stack depth, whose keep exceeds 128, or whose keep exceeds the depth left afterwards pulses `err` for one cycle and changes no state.
- R9: While `busy` is 1, allocate, release and register-write inputs are ignored.
- R10: `rd_data` shows the word at offset `rd_off` below the top, and `wr_en` writes the word at offset `wr_off`. The offset wraps modulo 128 across the circular file.
- R11: A register write in the same cycle as an accepted request uses the top from before the request. When allocate and release arrive together, only the allocate is performed.
- R12: Each memory request stays asserted with a stable address until `mem_ack`. Exactly one word moves per acknowledged cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Allocate request |
| alloc_size | input | 8 | Words to allocate (0..255; above 128 is an error) |
| rel_valid | input | 1 | Release request |
| rel_size | input | 8 | Words to release |
| rel_keep | input | 8 | Words under the new top that must be resident |
| busy | output | 1 | Spill or fill in progress |
| err | output | 1 | One-cycle pulse for a rejected request |
| resident | output | 8 | Words currently resident (0..128) |
| rd_off | input | 7 | Read offset below the top |
| rd_data | output | 32 | Read data |
| wr_en | input | 1 | Register write enable |
| wr_off | input | 7 | Write offset below the top |
| wr_data | input | 32 | Write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = spill write, 0 = fill read |
| mem_addr | output | 16 | Word address (memory stack pointer when idle) |
| mem_wdata | output | 32 | Spill data |
| mem_rdata | input | 32 | Fill data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory acknowledge |

## Verification
A register write and a stack request can land in the same cycle. The write must then go to the slot named by the old top, while the top moves at the same edge. The bench writes offset 0 and allocates in one cycle, then reads the word back at offset n. It also sends allocate and release together and checks that only the allocate happened. A scoreboard queue holds every spill and fill the reference model expects, by address, direction and data, and the memory responder pops and compares each one as it acknowledges.

// File: rtl/regstack_pkg.sv
// Shared types of the register stack cache.
package regstack_pkg;
    // Controller phase: idle, spilling to memory, or filling from memory.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SPILL = 2'd1,
        ST_FILL  = 2'd2
    } rs_state_e;
endpackage

// File: rtl/regstack_file.sv
// Circular register storage: one user write port, one fill write port, and
// two combinational read ports (user read and spill source).
// Assumes the controller never lets a user write and a fill write coincide.
module regstack_file #(
    parameter int AW = 7,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_we,
    input  logic [AW-1:0] a_idx,
    input  logic [DW-1:0] a_data,
    input  logic          b_we,
    input  logic [AW-1:0] b_idx,
    input  logic [DW-1:0] b_data,
    input  logic [AW-1:0] r0_idx,
    output logic [DW-1:0] r0_data,
    input  logic [AW-1:0] r1_idx,
    output logic [DW-1:0] r1_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    // Write one word per cycle; a fill takes precedence.
    always_ff @(posedge clk) begin
        if (b_we)
            store[b_idx] <= b_data;
        else if (a_we)
            store[a_idx] <= a_data;
    end

    // Read both ports combinationally.
    assign r0_data = store[r0_idx];
    assign r1_data = store[r1_idx];

    // R9: user writes are blocked while a fill is writing.
    a_r9_no_port_clash: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_we && b_we));
endmodule

// File: rtl/regstack_ctrl.sv
// Pointer and sequencing logic for the register stack cache. Holds the top
// and resident-bottom pointers (one wrap bit wider than the file index) and
// the memory stack pointer in words. Computes exact spill and fill counts
// and moves one word per memory acknowledge.
// Assumes the file depth is a power of two.
module regstack_ctrl
    import regstack_pkg::*;
#(
    parameter int AW  = 7,
    parameter int MAW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           alloc_valid,
    input  logic [AW:0]    alloc_size,
    input  logic           rel_valid,
    input  logic [AW:0]    rel_size,
    input  logic [AW:0]    rel_keep,
    input  logic           mem_ack,
    output logic           busy_o,
    output logic           err_o,
    output logic [AW:0]    resident_o,
    output logic [AW-1:0]  top_idx_o,
    output logic [AW-1:0]  bot_idx_o,
    output logic           fill_we_o,
    output logic [AW-1:0]  fill_idx_o,
    output logic           mem_req_o,
    output logic           mem_we_o,
    output logic [MAW-1:0] mem_addr_o
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
    localparam logic [PW:0]   DEPTH_S = (PW+1)'(DEPTH);

    rs_state_e      state;
    logic [PW-1:0]  tp, bp, cnt, pend;
    logic [MAW-1:0] msp;

    logic [PW-1:0]  resident, rn_c;
    logic [PW:0]    sum;
    logic [MAW-1:0] depth_w, newd;
    logic           alloc_bad, alloc_over, rel_bad, rel_all;

    // Decode occupancy, overflow and release checks from the current state.
    always_comb begin
        resident   = tp - bp;
        depth_w    = msp + MAW'(resident);
        sum        = {1'b0, resident} + {1'b0, alloc_size};
        alloc_bad  = alloc_size > DEPTH_P;
        alloc_over = sum > DEPTH_S;
        newd       = depth_w - MAW'(rel_size);
        rel_bad    = (MAW'(rel_size) > depth_w) || (rel_keep > DEPTH_P)
                     || (MAW'(rel_keep) > newd);
        rel_all    = rel_size >= resident;
        rn_c       = rel_all ? '0 : resident - rel_size;
    end

    // Accept requests when idle and step one word per acknowledge otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            tp    <= '0;
            bp    <= '0;
            msp   <= '0;
            cnt   <= '0;
            pend  <= '0;
            err_o <= 1'b0;
        end else begin
            err_o <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (alloc_valid) begin
                        if (alloc_bad) begin
                            err_o <= 1'b1;
                        end else if (alloc_over) begin
                            cnt   <= PW'(sum - DEPTH_S);
                            pend  <= alloc_size;
                            state <= ST_SPILL;
                        end else begin
                            tp <= tp + alloc_size;
                        end
                    end else if (rel_valid) begin
                        if (rel_bad) begin
                            err_o <= 1'b1;
                        end else begin
                            tp <= tp - rel_size;
                            if (rel_all) begin
                                bp  <= tp - rel_size;
                                msp <= newd;
                            end
                            if (rel_keep > rn_c) begin
                                cnt   <= rel_keep - rn_c;
                                state <= ST_FILL;
                            end
                        end
                    end
                end
                ST_SPILL: begin
                    if (mem_ack) begin
                        bp  <= bp + 1'b1;
                        msp <= msp + 1'b1;
                        cnt <= cnt - 1'b1;
                        if (cnt == PW'(1)) begin
                            tp    <= tp + pend;
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_FILL: begin
                    if (mem_ack) begin
                        bp  <= bp - 1'b1;
                        msp <= msp - 1'b1;
                        cnt <= cnt - 1'b1;
                        if (cnt == PW'(1))
                            state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the memory side and the indices the storage needs.
    assign busy_o     = state != ST_IDLE;
    assign mem_req_o  = state != ST_IDLE;
    assign mem_we_o   = state == ST_SPILL;
    assign mem_addr_o = (state == ST_FILL) ? msp - 1'b1 : msp;
    assign fill_we_o  = (state == ST_FILL) && mem_ack;
    assign fill_idx_o = AW'(bp - 1'b1);
    assign top_idx_o  = tp[AW-1:0];
    assign bot_idx_o  = bp[AW-1:0];
    assign resident_o = resident;

    // R2: occupancy never exceeds the file.
    a_r2_resident_bound: assert property (@(posedge clk) disable iff (!rst_n)
        resident_o <= DEPTH_P);
    // R3: every acknowledged spill advances the memory pointer by one word.
    a_r3_spill_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SPILL && mem_ack) |=> mem_addr_o == $past(msp) + 1'b1 || state == ST_FILL);
    // R6: every acknowledged fill moves the memory pointer back by one word.
    a_r6_fill_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL && mem_ack) |=> msp == $past(msp) - 1'b1);
    // R4 and R8: a rejected request leaves every pointer where it was.
    a_r4_r8_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (tp == $past(tp) && bp == $past(bp) && msp == $past(msp)));
    // R12: an unacknowledged request stays up with a stable address.
    a_r12_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack) |=> (mem_req_o && $stable(mem_addr_o) && $stable(tp)));
    // R5: a fill only ever starts from a release request.
    a_r5_fill_from_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_FILL) |-> $past(rel_valid && !alloc_valid));
endmodule

// File: rtl/regstack_cache.sv
// Variable-window register stack cache top: 128-word circular file in front
// of a word-wide backing store. Register offsets count down from the top.
// Assumes the memory holds mem_rdata valid in the cycle mem_ack is high.
module regstack_cache #(
    parameter int AW  = 7,
    parameter int DW  = 32,
    parameter int MAW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           alloc_valid,
    input  logic [AW:0]    alloc_size,
    input  logic           rel_valid,
    input  logic [AW:0]    rel_size,
    input  logic [AW:0]    rel_keep,
    output logic           busy,
    output logic           err,
    output logic [AW:0]    resident,
    input  logic [AW-1:0]  rd_off,
    output logic [DW-1:0]  rd_data,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_off,
    input  logic [DW-1:0]  wr_data,
    output logic           mem_req,
    output logic           mem_we,
    output logic [MAW-1:0] mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    input  logic           mem_ack
);
    logic [AW-1:0] top_idx, bot_idx, fill_idx, rd_idx, wr_idx;
    logic          fill_we, user_we;

    regstack_ctrl #(.AW(AW), .MAW(MAW)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_valid(alloc_valid),
        .alloc_size (alloc_size),
        .rel_valid  (rel_valid),
        .rel_size   (rel_size),
        .rel_keep   (rel_keep),
        .mem_ack    (mem_ack),
        .busy_o     (busy),
        .err_o      (err),
        .resident_o (resident),
        .top_idx_o  (top_idx),
        .bot_idx_o  (bot_idx),
        .fill_we_o  (fill_we),
        .fill_idx_o (fill_idx),
        .mem_req_o  (mem_req),
        .mem_we_o   (mem_we),
        .mem_addr_o (mem_addr)
    );

    // Map window offsets to physical slots below the top, modulo the depth.
    always_comb begin
        rd_idx  = top_idx - AW'(1) - rd_off;
        wr_idx  = top_idx - AW'(1) - wr_off;
        user_we = wr_en && !busy;
    end

    regstack_file #(.AW(AW), .DW(DW)) i_file (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_we   (user_we),
        .a_idx  (wr_idx),
        .a_data (wr_data),
        .b_we   (fill_we),
        .b_idx  (fill_idx),
        .b_data (mem_rdata),
        .r0_idx (rd_idx),
        .r0_data(rd_data),
        .r1_idx (bot_idx),
        .r1_data(mem_wdata)
    );
endmodule

// File: tb/test_regstack_cache.sv
`timescale 1ns/1ps
module test_regstack_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0, rel_valid = 1'b0, wr_en = 1'b0, mem_ack = 1'b0;
    logic [7:0]  alloc_size = '0, rel_size = '0, rel_keep = '0;
    logic [6:0]  rd_off = '0, wr_off = '0;
    logic [31:0] wr_data = '0, mem_rdata = '0;
    logic        busy, err, mem_req, mem_we;
    logic [7:0]  resident;
    logic [31:0] rd_data, mem_wdata;
    logic [15:0] mem_addr;

    regstack_cache i_regstack_cache (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_size(alloc_size),
        .rel_valid(rel_valid), .rel_size(rel_size), .rel_keep(rel_keep),
        .busy(busy), .err(err), .resident(resident),
        .rd_off(rd_off), .rd_data(rd_data),
        .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    always #4 clk = ~clk;   // 125 MHz

    int checks = 0, fails = 0;
    int hold_extra = 0;
    logic [48:0] expq[$];          // {we, addr[15:0], data[31:0]}
    logic [31:0] val [0:1023];     // model: word at each stack position
    logic [31:0] mem [0:1023];     // backing store
    int D = 0, R = 0, M = 0;

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Memory responder and scoreboard monitor.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req) begin
                repeat ($urandom_range(0, 2) + hold_extra) begin
                    @(negedge clk);
                    chk("R12", "req held during stall", mem_req, 1);
                end
                if (expq.size() == 0) begin
                    chk("R3", "unexpected memory access", 1, 0);
                end else begin
                    logic [48:0] it;
                    it = expq.pop_front();
                    chk(it[48] ? "R3" : "R6", "direction", mem_we, it[48]);
                    chk(it[48] ? "R3" : "R6", "address", mem_addr, it[47:32]);
                    if (it[48]) begin
                        chk("R3", "spill data", mem_wdata, it[31:0]);
                        mem[mem_addr[9:0]] = mem_wdata;
                    end else begin
                        mem_rdata = mem[mem_addr[9:0]];
                    end
                end
                mem_ack = 1'b1;
                @(negedge clk);
                mem_ack = 1'b0;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected done");
        summary();
    end

    task automatic wait_idle();
        @(negedge clk);
        while (busy || mem_ack) @(negedge clk);
    endtask

    task automatic check_state(string req);
        chk(req, "resident", resident, R);
        chk(req, "mem pointer", mem_addr, M);
        chk(req, "busy", busy, 0);
        chk(req, "pending traffic", expq.size(), 0);
    endtask

    task automatic check_reads(string req, int n);
        for (int o = 0; o < n; o++) begin
            rd_off = 7'(o);
            #1;
            chk(req, $sformatf("read offset %0d", o), rd_data, val[D-1-o]);
        end
    endtask

    task automatic write_window(int n, int seed);
        for (int o = 0; o < n; o++) begin
            wr_en = 1'b1; wr_off = 7'(o); wr_data = 32'(seed + o * 7);
            val[D-1-o] = 32'(seed + o * 7);
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    task automatic model_alloc(int n);
        int k;
        k = R + n - 128;
        if (k > 0) begin
            for (int p = M; p < M + k; p++) expq.push_back({1'b1, 16'(p), val[p]});
            M += k; R = 128;
        end else begin
            R += n;
        end
        D += n;
    endtask

    task automatic model_release(int n, int k);
        D -= n;
        if (n >= R) begin R = 0; M = D; end
        else R -= n;
        if (k > R) begin
            for (int i = 0; i < k - R; i++) expq.push_back({1'b0, 16'(M - 1 - i), 32'd0});
            M -= k - R; R = k;
        end
    endtask

    task automatic do_alloc(int n, string req);
        model_alloc(n);
        alloc_valid = 1'b1; alloc_size = 8'(n);
        @(negedge clk);
        alloc_valid = 1'b0;
        chk(req, "no error", err, 0);
        while (busy || mem_ack) @(negedge clk);
        check_state(req);
    endtask

    task automatic do_release(int n, int k, string req);
        model_release(n, k);
        rel_valid = 1'b1; rel_size = 8'(n); rel_keep = 8'(k);
        @(negedge clk);
        rel_valid = 1'b0;
        chk(req, "no error", err, 0);
        while (busy || mem_ack) @(negedge clk);
        check_state(req);
    endtask

    task automatic bad_req(bit is_alloc, int n, int k, string req);
        alloc_valid = is_alloc; alloc_size = 8'(n);
        rel_valid = !is_alloc; rel_size = 8'(n); rel_keep = 8'(k);
        @(negedge clk);
        alloc_valid = 1'b0; rel_valid = 1'b0;
        chk(req, "error pulse", err, 1);
        chk(req, "state kept", resident, R);
        chk(req, "pointer kept", mem_addr, M);
        @(negedge clk);
        chk(req, "error is one cycle", err, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values.
        chk("R1", "busy", busy, 0);
        chk("R1", "err", err, 0);
        chk("R1", "mem_req", mem_req, 0);
        chk("R1", "resident", resident, 0);
        chk("R1", "mem pointer", mem_addr, 0);

        // R2: windows that fit, no traffic.
        do_alloc(40, "R2"); write_window(40, 1000);
        do_alloc(50, "R2"); write_window(50, 2000);
        do_alloc(30, "R2"); write_window(30, 3000);
        check_reads("R10", 120);

        // R3: overflow spills exactly 12 oldest words.
        do_alloc(20, "R3"); write_window(20, 4000);
        check_reads("R10", 128);   // top has wrapped past slot 127

        // R4 and R8: rejected requests.
        bad_req(1, 200, 0, "R4");
        bad_req(1, 129, 0, "R4");
        bad_req(0, 141, 0, "R8");
        bad_req(0, 5, 129, "R8");
        bad_req(0, 100, 41, "R8");
        check_reads("R4", 128);

        // R5: return with enough resident words: no fill despite earlier spill.
        do_release(20, 30, "R5");
        // R6: return that exposes 2 spilled words.
        do_release(100, 10, "R6");
        check_reads("R6", 10);

        // R7: interrupt entry and return restore residency exactly.
        do_alloc(125, "R7"); write_window(125, 5000);
        do_release(125, 10, "R7");
        chk("R7", "resident restored", resident, 10);
        check_reads("R7", 10);

        // R11: write in the same cycle as an allocate hits the old top.
        model_alloc(4);
        val[D-5] = 32'hCAFE0001;
        wr_en = 1'b1; wr_off = 7'd0; wr_data = 32'hCAFE0001;
        alloc_valid = 1'b1; alloc_size = 8'd4;
        @(negedge clk);
        wr_en = 1'b0; alloc_valid = 1'b0;
        check_state("R11");
        write_window(4, 6000);
        rd_off = 7'd4; #1;
        chk("R11", "old-top write at offset 4", rd_data, 32'hCAFE0001);
        // R11: allocate wins over a simultaneous release.
        model_alloc(2);
        alloc_valid = 1'b1; alloc_size = 8'd2;
        rel_valid = 1'b1; rel_size = 8'd3; rel_keep = 8'd0;
        @(negedge clk);
        alloc_valid = 1'b0; rel_valid = 1'b0;
        check_state("R11");
        write_window(2, 7000);

        // R9: requests and writes during a held spill are ignored.
        hold_extra = 4;
        model_alloc(120);
        alloc_valid = 1'b1; alloc_size = 8'd120;
        @(negedge clk);
        alloc_valid = 1'b0;
        chk("R9", "busy during spill", busy, 1);
        rel_valid = 1'b1; rel_size = 8'd5; rel_keep = 8'd0;
        wr_en = 1'b1; wr_off = 7'd0; wr_data = 32'hDEAD0000;
        @(negedge clk);
        rel_valid = 1'b0; wr_en = 1'b0;
        while (busy || mem_ack) @(negedge clk);
        hold_extra = 0;
        check_state("R9");
        rd_off = 7'd120; #1;
        chk("R9", "write ignored while busy", rd_data, val[D-121]);

        // R5: release everything, pointer returns to zero.
        do_release(D, 0, "R5");
        chk("R5", "empty pointer", mem_addr, 0);

        repeat (4) @(negedge clk);
        summary();
    end
endmodule